// File: doc/BRIEF.md
# System Control Register File

This block holds the processor's control, debug and model-specific registers in one indexed array, reached through a single access port. Each access is either raw or architectural. A raw access moves the stored bits unchanged in either direction. An architectural access applies the register's own semantics:

- Some writes change neighbouring registers or raise one-cycle pulses toward the translation buffers and the mode decoder.
- Some reads return a computed view of the stored value instead of the bits themselves.

The access port is a plain one-cycle strobe and has no back-pressure. A write commits at the clock edge that samples it. A read answers one cycle later on `rsp_valid`/`rsp_data`. The side-effect pulses `flush_all`, `flush_ng`, `mode_upd` and `wr_err` also appear in that following cycle. The running cycle count comes in on `cycle_cnt` and is used only by the time-stamp register. The core number comes in on `core_id` and is used only by the interrupt-controller base register.

Register indices: 0 CR0, 1 CR2, 2 CR3, 3 CR4, 4 EFER, 5 code-segment attributes, 6 stack-segment attributes, 7 PAT, 8 MTRR capability, 9 machine-check capability, 10 system config, 11 top-of-memory, 12 DR6, 13 DR7, 14 APIC base, 15 TSC offset, 16 FPU status word, 17 x87 stack top, 18–25 segment bases (ES, CS, SS, DS, FS, GS, TR, IDTR), 26–33 effective bases in the same order (effective = base index + 8). Indices 34 and above are invalid.

Top module: `ctlreg_file`

## Requirements
- R1: After reset the following registers hold these values:
  - CR0 = 0x60000010, PAT = 0x0007040600070406, MTRR capability = 0x508, machine-check capability = 0x104, system config = 0x20601, top-of-memory = 0x4000000.
  - DR6 = 0xFFFF0FF0 (ones in bits 11:4 and 31:16), DR7 = 0x400, APIC base = 0xFEE00800 (base 0xFEE00000, enable at bit 11).
  - Every other register is 0, and all pulse outputs are low.
- R2: A raw write stores the data unchanged and raises no pulse. A raw read returns the stored value. Every valid read answers with `rsp_valid` high in the cycle after the request.
- R3: An architectural CR0 write always stores bit 4 as 1. If it changes bit 31 (paging), `flush_all` pulses. If EFER bit 8 (long-mode enable) is also set, EFER bit 10 (long-mode active) takes the new paging value.
- R4: An architectural CR3 write pulses `flush_ng`. An architectural CR4 write pulses `flush_all` only if it changes bit 4, bit 5 or bit 7.
- R5: An architectural write to the code-segment attributes that changes bit 9 (long mode) updates the ES, CS, SS and DS effective bases. Setting bit 9 clears them to 0; clearing it copies each one from its stored base.
- R6: An architectural write to the FS, GS, TR or IDTR base also writes its effective base. An architectural write to the ES, CS, SS or DS base does the same only when EFER bit 10 and attribute bit 9 are not both set.
- R7: An architectural TSC write stores the data minus `cycle_cnt`. An architectural TSC read returns the stored value plus `cycle_cnt`.
- R8: An architectural read of the FPU status word returns the stored word with bits 13:11 replaced by bits 2:0 of the x87 stack-top register.
- R9: An architectural read of the APIC base returns bit 8 set only when `core_id` is 0.
- R10: A write to an invalid index changes no register and pulses `wr_err`. A read of an invalid index returns 0.
- R11: An architectural write to CR0 or to either segment-attribute register pulses `mode_upd`. No other write does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_arch | input | 1 | 1 = architectural, 0 = raw |
| acc_idx | input | 6 | Register index |
| acc_wdata | input | 64 | Write data |
| cycle_cnt | input | 64 | Current cycle count |
| core_id | input | 8 | Core number |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 64 | Read data |
| wr_err | output | 1 | Pulse: write to an invalid index |
| flush_all | output | 1 | Pulse: flush every translation entry |
| flush_ng | output | 1 | Pulse: flush non-global entries |
| mode_upd | output | 1 | Pulse: mode decoder should recompute |

## Verification
The assertions assume `acc_en` is low or at a known level during and after reset, and that `acc_idx` and `acc_we` are never unknown while `acc_en` is high. Every stimulus task drives all access inputs at a falling edge and holds them for exactly one rising edge, so each access is sampled once. The bench keeps `cycle_cnt` constant across a TSC write and the read that checks it, so the offset arithmetic can be predicted exactly.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int XLEN     = 64;
  localparam int IDX_W    = 6;
  localparam int NUM_REGS = 34;
  localparam int CORE_W   = 8;
  localparam int SEG_GRP  = 4;   // bases shadowed by the long-mode switch
  localparam int SEG_ALL  = 8;
  localparam int EFF_OFS  = 8;

  typedef logic [XLEN-1:0]  word_t;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t RI_CR0 = 6'd0,  RI_CR2 = 6'd1,  RI_CR3 = 6'd2,  RI_CR4 = 6'd3;
  localparam idx_t RI_EFER = 6'd4, RI_CSA = 6'd5,  RI_SSA = 6'd6,  RI_PAT = 6'd7;
  localparam idx_t RI_MTCAP = 6'd8, RI_MCCAP = 6'd9, RI_SYSC = 6'd10, RI_TOPM = 6'd11;
  localparam idx_t RI_DBS = 6'd12, RI_DBC = 6'd13, RI_APIC = 6'd14, RI_TSC = 6'd15;
  localparam idx_t RI_FSW = 6'd16, RI_FTOP = 6'd17;
  localparam idx_t RI_BES = 6'd18, RI_BCS = 6'd19, RI_BSS = 6'd20, RI_BDS = 6'd21;
  localparam idx_t RI_BFS = 6'd22, RI_BGS = 6'd23, RI_BTR = 6'd24, RI_BIDT = 6'd25;
  localparam idx_t RI_EFF0 = 6'd26;

  localparam int B_ET  = 4;
  localparam int B_PG  = 31;
  localparam int B_LME = 8;
  localparam int B_LMA = 10;
  localparam int B_PSE = 4;
  localparam int B_PAE = 5;
  localparam int B_PGE = 7;
  localparam int B_CSL = 9;
  localparam int B_BSP = 8;
  localparam int FTOP_LO = 11;
  localparam int FTOP_W  = 3;

  typedef enum logic [1:0] {SEG_KEEP, SEG_ZERO, SEG_COPY} segfx_e;

  function automatic word_t rst_val(int i);
    case (i)
      int'(RI_CR0):   rst_val = 64'h0000_0000_6000_0010;
      int'(RI_PAT):   rst_val = 64'h0007_0406_0007_0406;
      int'(RI_MTCAP): rst_val = 64'h508;
      int'(RI_MCCAP): rst_val = 64'h104;
      int'(RI_SYSC):  rst_val = 64'h20601;
      int'(RI_TOPM):  rst_val = 64'h400_0000;
      int'(RI_DBS):   rst_val = 64'hFFFF_0FF0;
      int'(RI_DBC):   rst_val = 64'h400;
      int'(RI_APIC):  rst_val = 64'hFEE0_0800;
      default:        rst_val = '0;
    endcase
  endfunction
endpackage

// File: rtl/ctlreg_wr_fx.sv
module ctlreg_wr_fx
  import ctlreg_pkg::*;
(
  input  logic   arch,
  input  idx_t   idx,
  input  word_t  wdata,
  input  word_t  cycle,
  input  word_t  cur_main,
  input  word_t  cur_efer,
  input  word_t  cur_csa,
  output word_t  new_main,
  output logic   efer_wen,
  output word_t  efer_new,
  output segfx_e seg_fx,
  output logic   eff_wen,
  output logic   fl_all,
  output logic   fl_ng,
  output logic   mode_upd
);
  word_t tog;

  always_comb begin
    tog      = cur_main ^ wdata;
    new_main = wdata;
    efer_wen = 1'b0;
    efer_new = cur_efer;
    seg_fx   = SEG_KEEP;
    eff_wen  = 1'b0;
    fl_all   = 1'b0;
    fl_ng    = 1'b0;
    mode_upd = 1'b0;
    if (arch) begin
      case (idx)
        RI_CR0: begin
          new_main[B_ET] = 1'b1;
          mode_upd = 1'b1;
          fl_all   = tog[B_PG];
          if (tog[B_PG] && cur_efer[B_LME]) begin
            efer_wen        = 1'b1;
            efer_new[B_LMA] = wdata[B_PG];
          end
        end
        RI_CR3: fl_ng = 1'b1;
        RI_CR4: fl_all = tog[B_PAE] | tog[B_PSE] | tog[B_PGE];
        RI_CSA: begin
          mode_upd = 1'b1;
          if (tog[B_CSL]) seg_fx = wdata[B_CSL] ? SEG_ZERO : SEG_COPY;
        end
        RI_SSA: mode_upd = 1'b1;
        RI_BFS, RI_BGS, RI_BTR, RI_BIDT: eff_wen = 1'b1;
        RI_BES, RI_BCS, RI_BSS, RI_BDS:
          eff_wen = !(cur_efer[B_LMA] && cur_csa[B_CSL]);
        RI_TSC: new_main = wdata - cycle;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ctlreg_rd_fx.sv
module ctlreg_rd_fx
  import ctlreg_pkg::*;
(
  input  logic              arch,
  input  idx_t              idx,
  input  word_t             stored,
  input  logic [FTOP_W-1:0] ftop,
  input  word_t             cycle,
  input  logic [CORE_W-1:0] core_id,
  output word_t             view
);
  always_comb begin
    view = stored;
    if (arch) begin
      case (idx)
        RI_TSC:  view = stored + cycle;
        RI_FSW:  view[FTOP_LO +: FTOP_W] = ftop;
        RI_APIC: view[B_BSP] = (core_id == '0);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
  import ctlreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic              acc_arch,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [XLEN-1:0]   acc_wdata,
  input  logic [XLEN-1:0]   cycle_cnt,
  input  logic [CORE_W-1:0] core_id,
  output logic              rsp_valid,
  output logic [XLEN-1:0]   rsp_data,
  output logic              wr_err,
  output logic              flush_all,
  output logic              flush_ng,
  output logic              mode_upd
);
  word_t  regs [NUM_REGS];
  word_t  sel_val, new_main, efer_new, rd_view;
  logic   idx_ok, wr_go, rd_go;
  logic   efer_wen, eff_wen, fx_all, fx_ng, fx_mode;
  segfx_e seg_fx;

  assign idx_ok = acc_idx < idx_t'(NUM_REGS);
  assign wr_go  = acc_en & acc_we & idx_ok;
  assign rd_go  = acc_en & ~acc_we;

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (acc_idx == idx_t'(i)) sel_val = regs[i];
  end

  ctlreg_wr_fx u_wr (
    .arch(acc_arch), .idx(acc_idx), .wdata(acc_wdata), .cycle(cycle_cnt),
    .cur_main(sel_val), .cur_efer(regs[RI_EFER]), .cur_csa(regs[RI_CSA]),
    .new_main(new_main), .efer_wen(efer_wen), .efer_new(efer_new),
    .seg_fx(seg_fx), .eff_wen(eff_wen), .fl_all(fx_all), .fl_ng(fx_ng),
    .mode_upd(fx_mode)
  );

  ctlreg_rd_fx u_rd (
    .arch(acc_arch), .idx(acc_idx), .stored(sel_val),
    .ftop(regs[RI_FTOP][FTOP_W-1:0]), .cycle(cycle_cnt), .core_id(core_id),
    .view(rd_view)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= rst_val(i);
    end else if (wr_go) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (acc_idx == idx_t'(i)) regs[i] <= new_main;
      if (efer_wen) regs[RI_EFER] <= efer_new;
      for (int k = 0; k < SEG_ALL; k++)
        if (eff_wen && acc_idx == RI_BES + idx_t'(k))
          regs[int'(RI_BES) + EFF_OFS + k] <= acc_wdata;
      if (seg_fx != SEG_KEEP)
        for (int k = 0; k < SEG_GRP; k++)
          regs[int'(RI_EFF0) + k] <= (seg_fx == SEG_ZERO) ? '0 : regs[int'(RI_BES) + k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      wr_err    <= 1'b0;
      flush_all <= 1'b0;
      flush_ng  <= 1'b0;
      mode_upd  <= 1'b0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_data <= idx_ok ? rd_view : '0;
      wr_err    <= acc_en & acc_we & ~idx_ok;
      flush_all <= wr_go & fx_all;
      flush_ng  <= wr_go & fx_ng;
      mode_upd  <= wr_go & fx_mode;
    end
  end
endmodule

// File: rtl/ctlreg_chk.sv
module ctlreg_chk
  import ctlreg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             acc_en,
  input logic             acc_we,
  input logic             acc_arch,
  input logic [IDX_W-1:0] acc_idx,
  input logic             rsp_valid,
  input logic [XLEN-1:0]  rsp_data,
  input logic             wr_err,
  input logic             flush_all,
  input logic             flush_ng,
  input logic             mode_upd
);
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we) |=> rsp_valid); // R2
  AST_RAW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && !acc_arch) |=> (!flush_all && !flush_ng && !mode_upd)); // R2
  AST_CR3_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && acc_arch && acc_idx == RI_CR3) |=> flush_ng); // R4
  AST_BAD_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && acc_idx >= idx_t'(NUM_REGS)) |=> (wr_err && !flush_all && !flush_ng && !mode_upd)); // R10
  AST_BAD_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we && acc_idx >= idx_t'(NUM_REGS)) |=> (rsp_data == '0)); // R10
  AST_SSA_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && acc_arch && acc_idx == RI_SSA) |=> mode_upd); // R11
endmodule

bind ctlreg_file ctlreg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
  .acc_arch(acc_arch), .acc_idx(acc_idx), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .wr_err(wr_err), .flush_all(flush_all),
  .flush_ng(flush_ng), .mode_upd(mode_upd)
);

// File: tb/tb_ctlreg_file.sv
module tb_ctlreg_file;
  import ctlreg_pkg::*;
  localparam time CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic acc_en = 0, acc_we = 0, acc_arch = 0;
  logic [IDX_W-1:0] acc_idx = '0;
  logic [XLEN-1:0] acc_wdata = '0, cycle_cnt = '0;
  logic [CORE_W-1:0] core_id = '0;
  logic rsp_valid, wr_err, flush_all, flush_ng, mode_upd;
  logic [XLEN-1:0] rsp_data;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  ctlreg_file dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(bit arch, int idx, logic [63:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = 1; acc_arch = arch; acc_idx = IDX_W'(idx); acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
  endtask

  task automatic rd(bit arch, int idx, output logic [63:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = 0; acc_arch = arch; acc_idx = IDX_W'(idx);
    @(negedge clk);
    acc_en = 0;
    d = rsp_data;
    checks++;
    if (rsp_valid !== 1'b1) begin
      errors++;
      $display("FAIL R2 rsp_valid act=%b exp=1", rsp_valid);
    end
  endtask

  task automatic t_reset;
    logic [63:0] v;
    chk("R1 pulses", {flush_all, flush_ng, mode_upd, wr_err, rsp_valid}, 0);
    rd(0, 0, v);  chk("R1 CR0", v, 64'h60000010);
    rd(0, 7, v);  chk("R1 PAT", v, 64'h0007040600070406);
    rd(0, 8, v);  chk("R1 MTRRCAP", v, 64'h508);
    rd(0, 9, v);  chk("R1 MCCAP", v, 64'h104);
    rd(0, 10, v); chk("R1 SYSCFG", v, 64'h20601);
    rd(0, 11, v); chk("R1 TOPMEM", v, 64'h4000000);
    rd(0, 12, v); chk("R1 DR6", v, 64'hFFFF0FF0);
    rd(0, 13, v); chk("R1 DR7", v, 64'h400);
    rd(0, 14, v); chk("R1 APIC", v, 64'hFEE00800);
    rd(0, 2, v);  chk("R1 CR3", v, 0);
  endtask

  task automatic t_raw;
    logic [63:0] v;
    wr(0, 2, 64'h1234);
    chk("R2 raw no flush", {flush_ng, flush_all, mode_upd}, 0);
    rd(0, 2, v); chk("R2 raw CR3", v, 64'h1234);
    wr(0, 0, 64'h0);
    chk("R2 raw CR0 quiet", {flush_all, mode_upd}, 0);
    rd(0, 0, v); chk("R2 raw CR0 no ET", v, 0);
  endtask

  task automatic t_cr0;
    logic [63:0] v;
    wr(0, 4, 64'h100);
    wr(1, 0, 64'h80000001);
    chk("R3 PG on flush", flush_all, 1);
    chk("R11 CR0 mode", mode_upd, 1);
    rd(0, 0, v); chk("R3 ET forced", v, 64'h80000011);
    rd(0, 4, v); chk("R3 LMA set", v, 64'h500);
    wr(1, 0, 64'h1);
    chk("R3 PG off flush", flush_all, 1);
    rd(0, 4, v); chk("R3 LMA clear", v, 64'h100);
    wr(1, 0, 64'h1);
    chk("R3 no toggle no flush", flush_all, 0);
    wr(0, 4, 64'h0);
    wr(1, 0, 64'h80000000);
    chk("R3 flush without LME", flush_all, 1);
    rd(0, 4, v); chk("R3 EFER untouched", v, 0);
  endtask

  task automatic t_cr34;
    wr(1, 2, 64'h5000);
    chk("R4 CR3 flush_ng", flush_ng, 1);
    chk("R11 CR3 no mode", mode_upd, 0);
    wr(1, 3, 64'h20);
    chk("R4 PAE flush", flush_all, 1);
    wr(1, 3, 64'h21);
    chk("R4 other bit no flush", flush_all, 0);
    wr(1, 3, 64'h1);
    chk("R4 PAE off flush", flush_all, 1);
    wr(1, 6, 64'h1);
    chk("R11 SS attr mode", mode_upd, 1);
  endtask

  task automatic t_seg;
    logic [63:0] v;
    for (int k = 0; k < 4; k++) begin
      wr(0, 18 + k, 64'h100 * (k + 1));
      wr(0, 26 + k, 64'hAA);
    end
    wr(1, 5, 64'h200);
    for (int k = 0; k < 4; k++) begin
      rd(0, 26 + k, v); chk("R5 enter zero", v, 0);
    end
    wr(1, 5, 64'h0);
    for (int k = 0; k < 4; k++) begin
      rd(0, 26 + k, v); chk("R5 leave copy", v, 64'h100 * (k + 1));
    end
  endtask

  task automatic t_base;
    logic [63:0] v;
    wr(0, 4, 64'h500);
    wr(0, 5, 64'h200);
    wr(1, 21, 64'h555);
    rd(0, 29, v); chk("R6 DS eff held in 64b", v, 64'h400);
    rd(0, 21, v); chk("R6 DS base stored", v, 64'h555);
    wr(1, 22, 64'h777);
    rd(0, 30, v); chk("R6 FS eff always", v, 64'h777);
    wr(0, 5, 64'h0);
    wr(1, 21, 64'h999);
    rd(0, 29, v); chk("R6 DS eff outside 64b", v, 64'h999);
  endtask

  task automatic t_tsc;
    logic [63:0] v;
    cycle_cnt = 64'd1000;
    wr(1, 15, 64'd5000);
    rd(0, 15, v); chk("R7 stored offset", v, 64'd4000);
    cycle_cnt = 64'd1500;
    rd(1, 15, v); chk("R7 arch read", v, 64'd5500);
  endtask

  task automatic t_fsw;
    logic [63:0] v;
    wr(0, 16, 64'hFFFF);
    wr(0, 17, 64'h2);
    rd(1, 16, v); chk("R8 top merged", v, 64'hD7FF);
    rd(0, 16, v); chk("R8 raw intact", v, 64'hFFFF);
  endtask

  task automatic t_apic;
    logic [63:0] v;
    core_id = 0;
    rd(1, 14, v); chk("R9 core0 bsp", v, 64'hFEE00900);
    core_id = 3;
    rd(1, 14, v); chk("R9 core3 no bsp", v, 64'hFEE00800);
  endtask

  task automatic t_bad;
    logic [63:0] v;
    wr(1, 40, 64'hDEAD);
    chk("R10 err pulse", wr_err, 1);
    rd(1, 40, v); chk("R10 read zero", v, 0);
    rd(0, 0, v);  chk("R10 CR0 untouched", v, 64'h80000010);
    wr(0, 1, 64'h1);
    chk("R10 no err valid", wr_err, 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_raw;
    t_cr0;
    t_cr34;
    t_seg;
    t_base;
    t_tsc;
    t_fsw;
    t_apic;
    t_bad;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule